// File: doc/BRIEF.md
# Thread Context CAM Matcher

This block decides which privilege ring of one hardware thread, if any, owns an incoming notification target. A target is a block id, an index, a format bit, an ignore flag and a logical-server number. The thread's context supplies four ring words: hardware physical, hypervisor pool, OS and user. It also supplies the chip block id, the processor thread id and a thread-id-width setting. The block compares the target against these inputs and returns a ring code. If no ring matches, the code is none.

For ordinary targets (format 0, ignore 0) the three upper rings are tried in a fixed priority order. The physical ring has no stored line of its own. Its line is built on every request from the chip block id and a 7- or 8-bit thread id with a marker bit above it. A user-level branch target (format 1) takes a separate path. That path needs both a matching OS ring and a matching user ring. Logical-server targets (format 0, ignore 1) are not supported. They return none and raise an unimplemented flag.

The compare is combinational. A request presented with `reqValid` in one cycle is answered on the registered outputs after the next rising clock edge.

Top module: `cam_matcher`

## Requirements
- R1: While `rst_n` is low and after its release, until the first request, `rspValid`, `ringCode` and `unimplHit` are 0.
- R2: A request sampled with `reqValid` high at a rising edge is answered by `rspValid`=1 directly after that edge. In a cycle that answers no request, `rspValid`=0, `ringCode`=0 and `unimplHit`=0.
- R3: Each 32-bit ring word port carries its bytes in big-endian memory order. Port bits [8k+7:8k] hold memory byte k, and memory byte 0 is the most significant byte of the logical word. All field positions below refer to the logical word.
- R4: The target line is {tgtBlk, tgtIdx}, 24 bits. A pool or OS ring matches when logical bit 31 is 1 and logical bits [23:0] equal the target line.
- R5: The physical ring matches when its logical bit 31 is 1 and {chipBlk, physIdx} equals the target line. physIdx is a 1 at bit w OR'd with threadId masked to w bits, where w is 8 when `tid8Mode`=1 and 7 otherwise.
- R6: With format 0 and ignore 0, the first matching ring in the order physical, pool, OS gives the code. If none of them matches, the code is none.
- R7: With format 0 and ignore 1, the code is none and `unimplHit`=1, whatever the rings hold.
- R8: With format 1, the code is user only when the OS ring matches (per R4), the user word has logical bit 31 set, and the user word's logical bits [7:0] equal `tgtLs`. Otherwise the code is none. The physical and pool rings play no part.
- R9: With format 1, the ignore flag has no effect and `unimplHit` stays 0.
- R10: Ring codes are 0 none, 1 user, 2 OS, 3 pool, 4 physical. No other value appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | A target is presented this cycle |
| tgtBlk | input | 4 | Target block id |
| tgtIdx | input | 20 | Target index |
| tgtFmt | input | 1 | Target format: 0 thread target, 1 user-level branch |
| tgtIgnore | input | 1 | Logical-server (ignore low index bits) request |
| tgtLs | input | 8 | Requested logical-server number |
| physWord | input | 32 | Physical ring word, big-endian byte order |
| poolWord | input | 32 | Pool ring word, big-endian byte order |
| osWord | input | 32 | OS ring word, big-endian byte order |
| userWord | input | 32 | User ring word, big-endian byte order |
| chipBlk | input | 4 | Configured chip block id |
| threadId | input | 8 | Processor thread id |
| tid8Mode | input | 1 | 1 selects an 8-bit thread id, 0 a 7-bit one |
| rspValid | output | 1 | Result of the previous cycle's request |
| ringCode | output | 3 | Matched ring code |
| unimplHit | output | 1 | The request was an unsupported logical-server target |

## Verification
The only state is the output register, so any wrong internal decision shows at the ports one edge after the request and is gone one edge later. A wrong byte order, a misplaced valid bit or a wrong thread-id width appears as a none where a ring should match, or as a match that should not happen. A broken priority order appears as pool or OS when physical also matched. A stale output register appears as a nonzero code in a cycle that answers no request.

// File: rtl/cam_match_pkg.sv
package cam_match_pkg;

  typedef enum logic [2:0] {
    RING_NONE = 3'd0,
    RING_USER = 3'd1,
    RING_OS   = 3'd2,
    RING_POOL = 3'd3,
    RING_PHYS = 3'd4
  } ring_e;

  // per-ring compare results, datapath -> control
  typedef struct packed {
    logic phys;
    logic pool;
    logic os;
    logic user;
  } hit_t;

  // decision strobes, control -> output stage
  typedef struct packed {
    logic  load;
    ring_e code;
    logic  unimpl;
  } dec_t;

endpackage

// File: rtl/cam_byte_order.sv
module cam_byte_order #(
  parameter int WORD_W = 32
) (
  input  logic [WORD_W-1:0] memWord,
  output logic [WORD_W-1:0] logWord
);
  localparam int NBYTES = WORD_W / 8;

  // memory byte k becomes logical byte (NBYTES-1-k)
  for (genvar b = 0; b < NBYTES; b++) begin : g_byte
    assign logWord[8*(NBYTES-1-b) +: 8] = memWord[8*b +: 8];
  end
endmodule

// File: rtl/cam_match_dp.sv
module cam_match_dp
  import cam_match_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int BLK_W  = 4,
  parameter int IDX_W  = 20,
  parameter int LS_W   = 8,
  parameter int TID_W  = 8
) (
  input  logic [BLK_W-1:0]  tgtBlk,
  input  logic [IDX_W-1:0]  tgtIdx,
  input  logic [LS_W-1:0]   tgtLs,
  input  logic [WORD_W-1:0] physWord,
  input  logic [WORD_W-1:0] poolWord,
  input  logic [WORD_W-1:0] osWord,
  input  logic [WORD_W-1:0] userWord,
  input  logic [BLK_W-1:0]  chipBlk,
  input  logic [TID_W-1:0]  threadId,
  input  logic              tid8Mode,
  output hit_t              hits
);
  localparam int CAM_W     = BLK_W + IDX_W;
  localparam int VALID_BIT = WORD_W - 1;
  localparam int NRING     = 4;

  logic [NRING-1:0][WORD_W-1:0] memWords;
  logic [NRING-1:0][WORD_W-1:0] logWords;

  assign memWords[0] = physWord;
  assign memWords[1] = poolWord;
  assign memWords[2] = osWord;
  assign memWords[3] = userWord;

  for (genvar r = 0; r < NRING; r++) begin : g_ring
    cam_byte_order #(.WORD_W(WORD_W)) swap_i (
      .memWord(memWords[r]),
      .logWord(logWords[r])
    );
  end

  logic [CAM_W-1:0] tgtCam;
  logic [3:0]       tidW;
  logic [IDX_W-1:0] markBit;
  logic [IDX_W-1:0] physIdx;

  assign tgtCam  = {tgtBlk, tgtIdx};
  assign tidW    = tid8Mode ? 4'd8 : 4'd7;
  assign markBit = IDX_W'(1) << tidW;
  assign physIdx = markBit | (IDX_W'(threadId) & (markBit - IDX_W'(1)));

  assign hits.phys = logWords[0][VALID_BIT] && ({chipBlk, physIdx} == tgtCam);
  assign hits.pool = logWords[1][VALID_BIT] && (logWords[1][CAM_W-1:0] == tgtCam);
  assign hits.os   = logWords[2][VALID_BIT] && (logWords[2][CAM_W-1:0] == tgtCam);
  assign hits.user = logWords[3][VALID_BIT] && (logWords[3][LS_W-1:0] == tgtLs);

  logic unusedBits;
  assign unusedBits = ^{logWords[0][VALID_BIT-1:0],
                        logWords[1][VALID_BIT-1:CAM_W],
                        logWords[2][VALID_BIT-1:CAM_W],
                        logWords[3][VALID_BIT-1:LS_W]};
endmodule

// File: rtl/cam_match_ctrl.sv
module cam_match_ctrl
  import cam_match_pkg::*;
(
  input  logic reqValid,
  input  logic tgtFmt,
  input  logic tgtIgnore,
  input  hit_t hits,
  output dec_t dec
);
  always_comb begin
    dec.load   = reqValid;
    dec.code   = RING_NONE;
    dec.unimpl = 1'b0;
    if (tgtFmt) begin
      if (hits.os && hits.user) dec.code = RING_USER;
    end else if (tgtIgnore) begin
      dec.unimpl = 1'b1;
    end else if (hits.phys) begin
      dec.code = RING_PHYS;
    end else if (hits.pool) begin
      dec.code = RING_POOL;
    end else if (hits.os) begin
      dec.code = RING_OS;
    end
  end
endmodule

// File: rtl/cam_matcher.sv
module cam_matcher
  import cam_match_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int BLK_W  = 4,
  parameter int IDX_W  = 20,
  parameter int LS_W   = 8,
  parameter int TID_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reqValid,
  input  logic [BLK_W-1:0]  tgtBlk,
  input  logic [IDX_W-1:0]  tgtIdx,
  input  logic              tgtFmt,
  input  logic              tgtIgnore,
  input  logic [LS_W-1:0]   tgtLs,
  input  logic [WORD_W-1:0] physWord,
  input  logic [WORD_W-1:0] poolWord,
  input  logic [WORD_W-1:0] osWord,
  input  logic [WORD_W-1:0] userWord,
  input  logic [BLK_W-1:0]  chipBlk,
  input  logic [TID_W-1:0]  threadId,
  input  logic              tid8Mode,
  output logic              rspValid,
  output logic [2:0]        ringCode,
  output logic              unimplHit
);
  hit_t hits;
  dec_t dec;

  cam_match_dp #(
    .WORD_W(WORD_W), .BLK_W(BLK_W), .IDX_W(IDX_W), .LS_W(LS_W), .TID_W(TID_W)
  ) dp_i (
    .tgtBlk(tgtBlk), .tgtIdx(tgtIdx), .tgtLs(tgtLs),
    .physWord(physWord), .poolWord(poolWord), .osWord(osWord), .userWord(userWord),
    .chipBlk(chipBlk), .threadId(threadId), .tid8Mode(tid8Mode),
    .hits(hits)
  );

  cam_match_ctrl ctrl_i (
    .reqValid(reqValid), .tgtFmt(tgtFmt), .tgtIgnore(tgtIgnore),
    .hits(hits), .dec(dec)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rspValid  <= 1'b0;
      ringCode  <= RING_NONE;
      unimplHit <= 1'b0;
    end else if (dec.load) begin
      rspValid  <= 1'b1;
      ringCode  <= dec.code;
      unimplHit <= dec.unimpl;
    end else begin
      rspValid  <= 1'b0;
      ringCode  <= RING_NONE;
      unimplHit <= 1'b0;
    end
  end
endmodule

// File: rtl/cam_matcher_chk.sv
module cam_matcher_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       reqValid,
  input logic       tgtFmt,
  input logic       tgtIgnore,
  input logic       rspValid,
  input logic [2:0] ringCode,
  input logic       unimplHit
);
  // R2
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rspValid == $past(reqValid));

  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rspValid |-> (ringCode == 3'd0 && !unimplHit));

  // R7
  unimpl_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    unimplHit |-> $past(reqValid && !tgtFmt && tgtIgnore));

  // R7
  unimpl_no_ring_chk: assert property (@(posedge clk) disable iff (!rst_n)
    unimplHit |-> ringCode == 3'd0);

  // R8
  user_needs_fmt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ringCode == 3'd1) |-> $past(tgtFmt));

  // R9
  fmt1_no_unimpl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rspValid && $past(tgtFmt)) |-> !unimplHit);

  // R10
  code_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ringCode <= 3'd4);
endmodule

bind cam_matcher cam_matcher_chk chk_i (
  .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .tgtFmt(tgtFmt),
  .tgtIgnore(tgtIgnore), .rspValid(rspValid), .ringCode(ringCode),
  .unimplHit(unimplHit)
);

// File: tb/cam_matcher_tb_top.sv
`timescale 1ns/100ps
module cam_matcher_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reqValid = 1'b0;
  logic [3:0]  tgtBlk = '0;
  logic [19:0] tgtIdx = '0;
  logic        tgtFmt = 1'b0;
  logic        tgtIgnore = 1'b0;
  logic [7:0]  tgtLs = '0;
  logic [31:0] physWord = '0, poolWord = '0, osWord = '0, userWord = '0;
  logic [3:0]  chipBlk = '0;
  logic [7:0]  threadId = '0;
  logic        tid8Mode = 1'b0;
  logic        rspValid;
  logic [2:0]  ringCode;
  logic        unimplHit;

  int checkCnt = 0;
  int failCnt  = 0;
  bit done     = 1'b0;

  always #2.5 clk = ~clk;

  cam_matcher dut_i (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .tgtBlk(tgtBlk), .tgtIdx(tgtIdx),
    .tgtFmt(tgtFmt), .tgtIgnore(tgtIgnore), .tgtLs(tgtLs),
    .physWord(physWord), .poolWord(poolWord), .osWord(osWord), .userWord(userWord),
    .chipBlk(chipBlk), .threadId(threadId), .tid8Mode(tid8Mode),
    .rspValid(rspValid), .ringCode(ringCode), .unimplHit(unimplHit)
  );

  // R3: logical word -> port layout (memory byte 0 = logical MSB at port [7:0])
  function automatic logic [31:0] toPort(input logic [31:0] l);
    return {l[7:0], l[15:8], l[23:16], l[31:24]};
  endfunction

  function automatic logic [31:0] camWord(input logic v, input logic [3:0] b, input logic [19:0] i);
    return toPort({v, 7'd0, b, i});
  endfunction

  function automatic logic [31:0] userW(input logic v, input logic [7:0] ls);
    return toPort({v, 23'd0, ls});
  endfunction

  function automatic logic [31:0] physW(input logic v);
    return toPort({v, 31'd0});
  endfunction

  task automatic check(input string tag, input logic [4:0] act, input logic [4:0] exp);
    checkCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s: got rsp/code/unimpl=%b expected %b", tag, act, exp);
    end
  endtask

  // fire one request and check the answer one edge later
  task automatic fire(input string tag, input logic [2:0] expCode, input logic expUnimpl);
    reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    check(tag, {rspValid, ringCode, unimplHit}, {1'b1, expCode, expUnimpl});
  endtask

  task automatic clearRings();
    physWord = '0; poolWord = '0; osWord = '0; userWord = '0;
    tgtFmt = 1'b0; tgtIgnore = 1'b0;
  endtask

  task automatic tReset();
    check("R1 reset", {rspValid, ringCode, unimplHit}, 5'b0);
  endtask

  task automatic tIdle();
    @(negedge clk);
    check("R2 idle", {rspValid, ringCode, unimplHit}, 5'b0);
  endtask

  task automatic tPriority();
    clearRings();
    chipBlk = 4'h3; threadId = 8'h25; tid8Mode = 1'b0;
    tgtBlk = 4'h3; tgtIdx = 20'h000A5; // 0x80 | 0x25
    physWord = physW(1'b1);
    poolWord = camWord(1'b1, 4'h3, 20'h000A5);
    osWord   = camWord(1'b1, 4'h3, 20'h000A5);
    fire("R6 all match -> phys", 3'd4, 1'b0);
    physWord = physW(1'b0);
    fire("R6 phys invalid -> pool", 3'd3, 1'b0);
    poolWord = camWord(1'b1, 4'h3, 20'h000A4);
    fire("R4 pool mismatch -> os", 3'd2, 1'b0);
    osWord = camWord(1'b0, 4'h3, 20'h000A5);
    fire("R4 os invalid -> none", 3'd0, 1'b0);
    @(negedge clk);
    check("R2 answer lasts one cycle", {rspValid, ringCode, unimplHit}, 5'b0);
  endtask

  task automatic tPhysLine();
    clearRings();
    physWord = physW(1'b1);
    chipBlk = 4'h9; threadId = 8'hC5;
    tgtBlk = 4'h9; tgtIdx = 20'h001C5;
    tid8Mode = 1'b1;
    fire("R5 8-bit tid line", 3'd4, 1'b0);
    tid8Mode = 1'b0;
    fire("R5 7-bit tid no match", 3'd0, 1'b0);
    tgtIdx = 20'h000C5; // 0x80 | 0x45
    fire("R5 7-bit tid line", 3'd4, 1'b0);
    chipBlk = 4'h8;
    fire("R5 chip block mismatch", 3'd0, 1'b0);
  endtask

  task automatic tLogical();
    clearRings();
    chipBlk = 4'h1; threadId = 8'h00; tid8Mode = 1'b0;
    tgtBlk = 4'h1; tgtIdx = 20'h00080;
    physWord = physW(1'b1);
    poolWord = camWord(1'b1, 4'h1, 20'h00080);
    osWord   = camWord(1'b1, 4'h1, 20'h00080);
    tgtIgnore = 1'b1;
    fire("R7 ignore -> none+unimpl", 3'd0, 1'b1);
  endtask

  task automatic tUser();
    clearRings();
    chipBlk = 4'h2; threadId = 8'h11; tid8Mode = 1'b1;
    tgtBlk = 4'h2; tgtIdx = 20'h12345; tgtLs = 8'h5A;
    osWord   = camWord(1'b1, 4'h2, 20'h12345);
    userWord = userW(1'b1, 8'h5A);
    tgtFmt = 1'b1;
    fire("R8 os+user -> user", 3'd1, 1'b0);
    tgtIgnore = 1'b1;
    fire("R9 ignore has no effect in fmt1", 3'd1, 1'b0);
    tgtIgnore = 1'b0;
    tgtLs = 8'h5B;
    fire("R8 ls mismatch", 3'd0, 1'b0);
    tgtLs = 8'h5A;
    userWord = userW(1'b0, 8'h5A);
    fire("R8 user invalid", 3'd0, 1'b0);
    userWord = userW(1'b1, 8'h5A);
    osWord = camWord(1'b0, 4'h2, 20'h12345);
    fire("R8 os invalid", 3'd0, 1'b0);
    // physical and pool would match but do not count in fmt1
    threadId = 8'h45; tgtIdx = 20'h00145;
    physWord = physW(1'b1);
    poolWord = camWord(1'b1, 4'h2, 20'h00145);
    fire("R8 phys/pool ignored in fmt1", 3'd0, 1'b0);
    tgtFmt = 1'b0;
    fire("R10 fmt0 same rings -> phys code 4", 3'd4, 1'b0);
  endtask

  task automatic tByteOrder();
    clearRings();
    tgtBlk = 4'h7; tgtIdx = 20'hABCDE;
    osWord = {1'b1, 7'd0, 4'h7, 20'hABCDE}; // logical layout, not swapped
    fire("R3 unswapped word ignored", 3'd0, 1'b0);
    osWord = camWord(1'b1, 4'h7, 20'hABCDE);
    fire("R3 swapped word matches", 3'd2, 1'b0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checkCnt++; failCnt++;
      $display("FAIL watchdog: got hung expected finish");
      $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    tReset();
    rst_n = 1'b1;
    @(negedge clk);
    tReset();
    tIdle();
    tPriority();
    tPhysLine();
    tLogical();
    tUser();
    tByteOrder();
    tIdle();
    done = 1'b1;
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end
endmodule